// File: doc/BRIEF.md
# Bidirectional open-drain bus repeater

This block is a clocked digital model of a two-port repeater for a two-wire open-drain bus. It has one clock channel and one data channel, and both are built from the same direction-control core. Each side of each wire gives the block a sampled line level. For each side the block returns a pull-down request. The pull-up and the wired-AND of all drivers are outside the block.

When one side of a wire is seen low first, the block pulls the other side low. When the originating side comes back high, the block lets the other side go. The block then ignores the low it caused itself on that side until that low has had time to clear through the input synchronizer. This keeps the two sides from holding each other low.

A device that is still holding the released side low after that window is treated as a real external low and is passed back across. This keeps clock stretching and arbitration working through the repeater.

All drivers are gated by an enable input and by two supply-good inputs. An enable change is applied only while the bus is quiet and no transfer is open. Enable should be high at least 100 ns before a START and stay high at least 100 ns after a STOP.

Top module: `od_repeater`

## Requirements
- R1: During reset and after reset, with no external device holding any line low, all four pull-down outputs are 0 and all four lines read high.
- R2: An external low on side A of a wire sets that wire's side-B pull-down on the third rising clock edge after the low appears (two synchronizer stages plus one state register). Releasing side A clears the side-B pull-down with the same three-edge latency.
- R3: An external low on side B of a wire, seen while the wire is idle, sets that wire's side-A pull-down. The pull-down is cleared three edges after side B returns high.
- R4: After the block releases a side, that side's input is ignored for three cycles (synchronizer depth plus one). If the side then reads high, neither pull-down of that wire is set, so the block causes no lock-up.
- R5: If a side that the block released still reads low at the end of the ignore window, the low is treated as external and the opposite side is pulled low. This lasts until the holder releases. This covers, for example, a device stretching side B after side A has risen.
- R6: A low that appears on both sides of a wire in the same cycle resolves as side A driving side B: the side-B pull-down is set and the side-A pull-down is not.
- R7: Pull-downs are asserted only while both supply-good inputs (1 = good) are high. With either one low, no low is forwarded. Forwarding resumes whichever supply comes up last.
- R8: The enable input is active high. Once a low enable has been applied, no pull-down is asserted for any low on any side. After enable is applied high again, forwarding resumes.
- R9: An enable change is applied only while all four lines read high and no transfer is open. A START is the data line (both sides ANDed) falling while the clock line (both sides ANDed) is high. A STOP is the data line rising while the clock line is high. Between a START and its STOP, the old enable stays in force, even at moments when every line is high.
- R10: For any pattern of external holds on one wire followed by any second pattern, once every external device releases, both pull-downs of that wire clear and both of its lines read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in | input | 1 | Repeater enable, 1 = forward |
| pwr_ok_a | input | 1 | Side-A supply good |
| pwr_ok_b | input | 1 | Side-B supply good |
| a_scl_i | input | 1 | Side-A clock line level |
| a_sda_i | input | 1 | Side-A data line level |
| b_scl_i | input | 1 | Side-B clock line level |
| b_sda_i | input | 1 | Side-B data line level |
| a_scl_pd | output | 1 | Pull-down request for side-A clock |
| a_sda_pd | output | 1 | Pull-down request for side-A data |
| b_scl_pd | output | 1 | Pull-down request for side-B clock |
| b_sda_pd | output | 1 | Pull-down request for side-B data |

## Verification
The hardest case to reach from the ports is a second device holding the side that the block is itself pulling down. On the wired-AND the two lows cannot be told apart. The stimulus holds side A low, adds an external hold on side B, and then releases side A. The pass-back must appear only after the ignore window.

A second hard case is a moment in the middle of a transfer when every line is high, so the bus looks quiet but is not. The bench reaches it by framing a data bit between a START and a STOP, with enable changed in the middle of that frame. An exhaustive sweep over all ordered pairs of hold patterns on each wire then confirms that every release ends with both sides free.

// File: rtl/rep_pkg.sv
package rep_pkg;
  localparam int REP_CH = 2;

  typedef enum logic [2:0] {
    DIR_IDLE  = 3'd0,
    DIR_A2B   = 3'd1,
    DIR_B2A   = 3'd2,
    DIR_HOLDB = 3'd3,
    DIR_HOLDA = 3'd4
  } dir_t;
endpackage

// File: rtl/rep_sync.sv
module rep_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rep_channel.sv
module rep_channel
  import rep_pkg::*;
#(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic a_in,
  input  logic b_in,
  output logic drv_a,
  output logic drv_b
);
  localparam int CW = (SETTLE > 2) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  dir_t          state, state_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    if (!run) begin
      state_n = DIR_IDLE;
      cnt_n   = '0;
    end else begin
      case (state)
        DIR_IDLE: begin
          if (!a_in)      state_n = DIR_A2B;
          else if (!b_in) state_n = DIR_B2A;
        end
        DIR_A2B: begin
          if (a_in) begin
            state_n = DIR_HOLDB;
            cnt_n   = '0;
          end
        end
        DIR_B2A: begin
          if (b_in) begin
            state_n = DIR_HOLDA;
            cnt_n   = '0;
          end
        end
        DIR_HOLDB: begin
          if (!a_in)            state_n = DIR_A2B;
          else if (cnt == LAST) state_n = b_in ? DIR_IDLE : DIR_B2A;
          else                  cnt_n = cnt + 1'b1;
        end
        DIR_HOLDA: begin
          if (!b_in)            state_n = DIR_B2A;
          else if (cnt == LAST) state_n = a_in ? DIR_IDLE : DIR_A2B;
          else                  cnt_n = cnt + 1'b1;
        end
        default: state_n = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= DIR_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

  assign drv_a = run && (state == DIR_B2A);
  assign drv_b = run && (state == DIR_A2B);

  // R2
  b_drive_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_b) |-> $past(!a_in));
  // R3
  a_drive_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_a) |-> $past(!b_in));
  // R6
  tie_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state == DIR_IDLE && !a_in && !b_in) |=> (drv_b || !run));
endmodule

// File: rtl/rep_ctrl.sv
module rep_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic pga_s,
  input  logic pgb_s,
  input  logic [1:0] a_in,
  input  logic [1:0] b_in,
  output logic run
);
  logic scl, sda, scl_q, sda_q;
  logic busy, busy_n, en_on, en_on_n, run_n;
  logic start, stop, quiet;

  assign scl   = a_in[0] & b_in[0];
  assign sda   = a_in[1] & b_in[1];
  assign start = scl & scl_q & sda_q & !sda;
  assign stop  = scl & scl_q & !sda_q & sda;
  assign quiet = scl & sda & !busy;

  always_comb begin
    busy_n = busy;
    if (start)     busy_n = 1'b1;
    else if (stop) busy_n = 1'b0;
    en_on_n = quiet ? en_s : en_on;
    run_n   = en_on_n & pga_s & pgb_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
      en_on <= 1'b0;
      run   <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      busy  <= busy_n;
      en_on <= en_on_n;
      run   <= run_n;
    end
  end

  // R9
  en_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(en_on));
endmodule

// File: rtl/od_repeater.sv
module od_repeater
  import rep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  input  logic pwr_ok_a,
  input  logic pwr_ok_b,
  input  logic a_scl_i,
  input  logic a_sda_i,
  input  logic b_scl_i,
  input  logic b_sda_i,
  output logic a_scl_pd,
  output logic a_sda_pd,
  output logic b_scl_pd,
  output logic b_sda_pd
);
  localparam int SETTLE = SYNC_STAGES + 1;

  logic [REP_CH-1:0] a_in, b_in, drv_a, drv_b;
  logic [2:0] ctl_s;
  logic run;

  rep_sync #(.W(2*REP_CH), .STAGES(SYNC_STAGES), .RST_VAL({(2*REP_CH){1'b1}})) u_line_sync (
    .clk(clk), .rst_n(rst_n),
    .d({b_sda_i, b_scl_i, a_sda_i, a_scl_i}),
    .q({b_in, a_in})
  );

  rep_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pwr_ok_b, pwr_ok_a, en_in}),
    .q(ctl_s)
  );

  rep_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .en_s(ctl_s[0]), .pga_s(ctl_s[1]), .pgb_s(ctl_s[2]),
    .a_in(a_in), .b_in(b_in),
    .run(run)
  );

  for (genvar c = 0; c < REP_CH; c++) begin : g_ch
    rep_channel #(.SETTLE(SETTLE)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run),
      .a_in(a_in[c]), .b_in(b_in[c]),
      .drv_a(drv_a[c]), .drv_b(drv_b[c])
    );
  end

  assign a_scl_pd = drv_a[0];
  assign a_sda_pd = drv_a[1];
  assign b_scl_pd = drv_b[0];
  assign b_sda_pd = drv_b[1];

  // R7
  supply_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_s[1] || !ctl_s[2]) |=> !(a_scl_pd || a_sda_pd || b_scl_pd || b_sda_pd));
endmodule

// File: tb/tb_od_repeater.sv
module tb_od_repeater;
  logic clk = 1'b0;
  logic rst_n;
  logic en, pga, pgb;
  logic [1:0] ea, eb;
  logic [1:0] pa, pb, la, lb;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign la = ~ea & ~pa;
  assign lb = ~eb & ~pb;

  od_repeater dut (
    .clk(clk), .rst_n(rst_n), .en_in(en), .pwr_ok_a(pga), .pwr_ok_b(pgb),
    .a_scl_i(la[0]), .a_sda_i(la[1]), .b_scl_i(lb[0]), .b_sda_i(lb[1]),
    .a_scl_pd(pa[0]), .a_sda_pd(pa[1]), .b_scl_pd(pb[0]), .b_sda_pd(pb[1])
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; pga = 1'b1; pgb = 1'b1; ea = 2'b00; eb = 2'b00;
    cyc(3);
    chk("R1 pulldowns in reset", {4'h0, pb, pa}, 8'h00);
    rst_n = 1'b1;
    cyc(8);
    chk("R1 pulldowns after reset", {4'h0, pb, pa}, 8'h00);
    chk("R1 lines after reset", {4'h0, lb, la}, 8'h0F);

    // R2 exact latency on the clock wire
    ea[0] = 1'b1;
    cyc(2);
    chk("R2 b_scl before third edge", {7'h0, pb[0]}, 8'h00);
    cyc(1);
    chk("R2 b_scl on third edge", {7'h0, pb[0]}, 8'h01);
    chk("R2 side A not driven", {6'h0, pa}, 8'h00);
    ea[0] = 1'b0;
    cyc(2);
    chk("R2 b_scl held before third edge", {7'h0, pb[0]}, 8'h01);
    cyc(1);
    chk("R2 b_scl released on third edge", {7'h0, pb[0]}, 8'h00);
    cyc(1);
    chk("R4 own low ignored in window", {4'h0, pb, pa}, 8'h00);
    cyc(5);
    chk("R4 settled idle", {lb, la, pb, pa}, 8'hF0);

    // R3 side B first on the data wire
    eb[1] = 1'b1;
    cyc(3);
    chk("R3 a_sda driven", {4'h0, pb, pa}, 8'h02);
    eb[1] = 1'b0;
    cyc(3);
    chk("R3 a_sda released", {7'h0, pa[1]}, 8'h00);
    cyc(6);
    chk("R4 no lockup after B release", {lb, la, pb, pa}, 8'hF0);

    // R6 same-cycle low on both sides
    ea[0] = 1'b1; eb[0] = 1'b1;
    cyc(3);
    chk("R6 tie resolves A to B", {4'h0, pb, pa}, 8'h04);
    ea[0] = 1'b0; eb[0] = 1'b0;
    cyc(12);
    chk("R6 tie released", {lb, la, pb, pa}, 8'hF0);

    // R5 external holder on side B passed back to A
    ea[0] = 1'b1;
    cyc(4);
    eb[0] = 1'b1;
    cyc(3);
    ea[0] = 1'b0;
    cyc(3);
    chk("R5 inside window no drive", {4'h0, pb, pa}, 8'h00);
    cyc(6);
    chk("R5 stretch passed to A", {4'h0, pb, pa}, 8'h01);
    chk("R5 side A line low", {7'h0, la[0]}, 8'h00);
    eb[0] = 1'b0;
    cyc(12);
    chk("R5 all released", {lb, la, pb, pa}, 8'hF0);

    // R7 supply-good combinations, both power-up orders
    begin
      logic [1:0] seq [6] = '{2'b00, 2'b01, 2'b11, 2'b00, 2'b10, 2'b11};
      for (int i = 0; i < 6; i++) begin
        {pgb, pga} = seq[i];
        cyc(6);
        ea[0] = 1'b1;
        cyc(6);
        chk($sformatf("R7 supplies=%b", seq[i]), {7'h0, pb[0]}, {7'h0, (seq[i] == 2'b11)});
        ea[0] = 1'b0;
        cyc(10);
      end
    end

    // R8 enable gating while idle
    en = 1'b0;
    cyc(8);
    ea[0] = 1'b1;
    cyc(6);
    chk("R8 disabled A low", {4'h0, pb, pa}, 8'h00);
    ea[0] = 1'b0;
    cyc(6);
    eb[1] = 1'b1;
    cyc(6);
    chk("R8 disabled B low", {4'h0, pb, pa}, 8'h00);
    eb[1] = 1'b0;
    cyc(8);
    en = 1'b1;
    cyc(8);
    ea[0] = 1'b1;
    cyc(6);
    chk("R8 re-enabled forwards", {4'h0, pb, pa}, 8'h04);
    ea[0] = 1'b0;
    cyc(10);

    // R9 enable deferred across an open transfer
    ea[1] = 1'b1;
    cyc(6);
    chk("R9 START forwarded", {7'h0, pb[1]}, 8'h01);
    en = 1'b0;
    cyc(8);
    ea[0] = 1'b1;
    cyc(6);
    chk("R9 clock low still forwarded", {7'h0, pb[0]}, 8'h01);
    ea[1] = 1'b0;
    cyc(8);
    ea[0] = 1'b0;
    cyc(8);
    chk("R9 all high inside transfer", {4'h0, lb, la}, 8'h0F);
    ea[0] = 1'b1;
    cyc(6);
    chk("R9 still enabled mid transfer", {7'h0, pb[0]}, 8'h01);
    ea[1] = 1'b1;
    cyc(6);
    ea[0] = 1'b0;
    cyc(8);
    ea[1] = 1'b0;
    cyc(10);
    ea[0] = 1'b1;
    cyc(6);
    chk("R9 disable applied after STOP", {4'h0, pb, pa}, 8'h00);
    ea[0] = 1'b0;
    cyc(6);
    en = 1'b1;
    cyc(8);
    ea[0] = 1'b1;
    cyc(6);
    chk("R9 enable applied when quiet", {7'h0, pb[0]}, 8'h01);
    ea[0] = 1'b0;
    cyc(10);

    // R10 sweep of hold-pattern pairs on each wire
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < 4; p++) begin
        for (int q = 0; q < 4; q++) begin
          ea[ch] = p[0]; eb[ch] = p[1];
          cyc(8);
          ea[ch] = q[0]; eb[ch] = q[1];
          cyc(8);
          ea[ch] = 1'b0; eb[ch] = 1'b0;
          cyc(14);
          chk($sformatf("R10 wire=%0d first=%0d second=%0d", ch, p, q),
              {lb, la, pb, pa}, 8'hF0);
        end
      end
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule